// File: doc/BRIEF.md
# Iterative Fixed-Point Softmax Unit

The unit turns a short vector of signed fixed-point scores into a probability vector. Software or a neighbouring block first writes the elements through a load port, pulses `start`, and later collects one normalized value per element on a streamed output. No exponential table is used: each exponential is assembled from sixteen stored per-bit constants by one multiplier that folds in one constant for every set bit of the argument.

Processing runs in four phases. The largest element is found first. Every element's distance below that maximum is then raised to an exponential bit by bit. The exponentials are summed, and each is divided by the sum with a restoring shift-subtract divider. Because the maximum element has a distance of zero, its exponential is exactly 1.0 and the sum can never be smaller than any single term. The constant register file can be rewritten while the unit is idle, so the scale of the arguments is set by its contents.

Top module: `softmax_iter`

## Requirements
- R1: After reset `busy`, `done` and `out_valid` are low and `out_data` is zero.
- R2: A `start` pulse while idle raises `busy` in the next cycle; `busy` stays high until the last output has been presented.
- R3: Elements are 16-bit two's complement. For each element the distance d = max − x is taken as a 16-bit unsigned value (it cannot exceed 65535). Its exponential is the product, over every set bit d[15−n], of constant entry n; clear bits leave the product unchanged. With entry 0 = e^(−256) and entry n = e^(−2^(8−n)) for n = 1..15, this gives e^(−d/128).
- R4: Constants and exponentials are unsigned Q2.14. The running product starts at 16384 (1.0); each multiply is rounded as (p·c + 8192) >> 14 and saturates to 65535.
- R5: The maximum element always gets an exponential of exactly 1.0, so adding one constant to every element leaves the outputs unchanged, and equal elements give equal outputs.
- R6: Output i is floor(e_i · 65536 / S), where S is the sum of all LEN exponentials. The value is saturated to 65535 (Q0.16).
- R7: Outputs appear with `out_valid` high for LEN consecutive cycles, in element-index order. The first one appears 34·LEN cycles after the edge that accepted `start`.
- R8: `done` is a one-cycle pulse in the cycle right after the last valid output, with `busy` already low.
- R9: While busy, vector writes, constant writes and further `start` pulses have no effect on the current run or on the stored state.
- R10: Constant writes made while idle take effect on the next run (for example, all entries at 16384 give uniform outputs).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Write one vector element |
| ld_idx | input | $clog2(LEN) | Element index for the write |
| ld_data | input | DW | Element value, two's complement |
| cw_en | input | 1 | Write one constant entry |
| cw_addr | input | $clog2(DW) | Constant entry index |
| cw_data | input | CW | Constant value, unsigned Q2.14 |
| start | input | 1 | Begin a softmax run |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| out_valid | output | 1 | `out_data` holds a result |
| out_data | output | CW | Normalized result, unsigned Q0.16 |

## Verification
Timing is fixed by the phase lengths: LEN cycles to find the maximum, 16 per element for the exponent, 17 per element for the divide, and then LEN output cycles. The first result is due 34·LEN cycles after the accepting edge, and `done` is due exactly one cycle after the last result. The bench counts falling edges from the accepting edge and expects `out_valid` to rise on exactly that count, not earlier or later. A monitor samples on falling edges and compares each valid output with the next expected value from a queue filled by the driver. The driver checks the `done`, `busy` and `out_valid` levels in the single cycle after the stream ends.

// File: rtl/softmax_iter.sv
module softmax_iter #(
  parameter int LEN = 8,
  parameter int DW  = 16,
  parameter int CW  = 16,
  parameter int FB  = 14,
  localparam int IW = $clog2(LEN),
  localparam int AW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [IW-1:0] ld_idx,
  input  logic [DW-1:0] ld_data,
  input  logic          cw_en,
  input  logic [AW-1:0] cw_addr,
  input  logic [CW-1:0] cw_data,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          out_valid,
  output logic [CW-1:0] out_data
);
  localparam int SW  = CW + IW + 1;
  localparam int CNW = $clog2(CW + 1);
  localparam logic [CW-1:0] ONE = CW'(1) << FB;

  typedef enum logic [2:0] {S_IDLE, S_MAX, S_EXP, S_DIV, S_OUT} st_t;
  st_t state;

  logic [DW-1:0] xv [LEN];
  logic [CW-1:0] cf [DW];
  logic [CW-1:0] ev [LEN];
  logic signed [DW-1:0] mx;
  logic [IW-1:0]  k;
  logic [AW-1:0]  b;
  logic [CNW-1:0] c;
  logic [CW-1:0]  prod;
  logic [SW-1:0]  sum, rem;
  logic [CW:0]    q;

  logic signed [DW-1:0] xk;
  logic [DW-1:0]   mag;
  logic            bit_set;
  logic [2*CW-1:0] mul, rnd;
  logic [CW-1:0]   msat, pnext;
  logic [SW-1:0]   rin;
  logic [SW:0]     trial, rdiff;
  logic            ge;
  logic [CW:0]     qn;
  logic [CW-1:0]   qsat;
  logic            last_k;

  assign xk      = xv[k];
  assign mag     = mx - xk;
  assign bit_set = mag[AW'(DW-1) - b];
  assign mul     = prod * cf[b];
  assign rnd     = (mul + (2*CW)'(1 << (FB-1))) >> FB;
  assign msat    = (|rnd[2*CW-1:CW]) ? '1 : rnd[CW-1:0];
  assign pnext   = bit_set ? msat : prod;

  assign rin   = (c == '0) ? SW'(ev[k] >> 1) : rem;
  assign trial = {rin, (c == '0) ? ev[k][0] : 1'b0};
  assign ge    = trial >= {1'b0, sum};
  assign rdiff = ge ? trial - {1'b0, sum} : trial;
  assign qn    = (c == '0) ? (CW+1)'(ge) : {q[CW-1:0], ge};
  assign qsat  = qn[CW] ? '1 : qn[CW-1:0];
  assign last_k = (k == IW'(LEN-1));

  assign busy      = (state != S_IDLE);
  assign out_valid = (state == S_OUT);
  assign out_data  = out_valid ? ev[k] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      done  <= 1'b0;
      mx    <= '0;
      k     <= '0;
      b     <= '0;
      c     <= '0;
      prod  <= ONE;
      sum   <= '0;
      rem   <= '0;
      q     <= '0;
      for (int i = 0; i < LEN; i++) begin
        xv[i] <= '0;
        ev[i] <= '0;
      end
      for (int i = 0; i < DW; i++) cf[i] <= '0;
    end else begin
      done <= 1'b0;
      if (state == S_IDLE && ld_en) xv[ld_idx] <= ld_data;
      if (state == S_IDLE && cw_en) cf[cw_addr] <= cw_data;
      case (state)
        S_IDLE: if (start) begin
          state <= S_MAX;
          k     <= '0;
        end
        S_MAX: begin
          if (k == '0 || xk > mx) mx <= xk;
          if (last_k) begin
            k     <= '0;
            b     <= '0;
            prod  <= ONE;
            sum   <= '0;
            state <= S_EXP;
          end else k <= k + 1'b1;
        end
        S_EXP: begin
          if (b == AW'(DW-1)) begin
            ev[k] <= pnext;
            sum   <= sum + SW'(pnext);
            prod  <= ONE;
            b     <= '0;
            if (last_k) begin
              k     <= '0;
              c     <= '0;
              state <= S_DIV;
            end else k <= k + 1'b1;
          end else begin
            prod <= pnext;
            b    <= b + 1'b1;
          end
        end
        S_DIV: begin
          rem <= rdiff[SW-1:0];
          q   <= qn;
          if (c == CNW'(CW)) begin
            ev[k] <= qsat;
            c     <= '0;
            if (last_k) begin
              k     <= '0;
              state <= S_OUT;
            end else k <= k + 1'b1;
          end else c <= c + 1'b1;
        end
        S_OUT: begin
          if (last_k) begin
            k     <= '0;
            done  <= 1'b1;
            state <= S_IDLE;
          end else k <= k + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module softmax_iter_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic out_valid
);
  p_busy_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  p_busy_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !out_valid) |=> busy);
  p_valid_while_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);
  p_done_follows_stream_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid));
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !out_valid));
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind softmax_iter softmax_iter_chk u_chk (.*);

// File: tb/softmax_iter_tb.sv
module softmax_iter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LEN = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0;
  logic [2:0]  ld_idx = '0;
  logic [15:0] ld_data = '0;
  logic        cw_en = 1'b0;
  logic [3:0]  cw_addr = '0;
  logic [15:0] cw_data = '0;
  logic        start = 1'b0;
  logic        busy, done, out_valid;
  logic [15:0] out_data;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  string cur_req = "R1";
  int cst[16];
  int vec[LEN];

  softmax_iter #(.LEN(LEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .cw_en(cw_en), .cw_addr(cw_addr), .cw_data(cw_data), .start(start),
    .busy(busy), .done(done), .out_valid(out_valid), .out_data(out_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) check(1'b0, cur_req, out_data, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        check(out_data == 16'(e), cur_req, out_data, e);
      end
    end
  end

  task automatic push_expected();
    int mx;
    longint e[LEN];
    longint s;
    mx = vec[0];
    for (int i = 1; i < LEN; i++) if (vec[i] > mx) mx = vec[i];
    s = 0;
    for (int i = 0; i < LEN; i++) begin
      int d;
      longint p;
      d = mx - vec[i];
      p = 16384;
      for (int n = 0; n < 16; n++) begin
        if (d[15-n]) begin
          p = (p * cst[n] + 8192) >>> 14;
          if (p > 65535) p = 65535;
        end
      end
      e[i] = p;
      s += p;
    end
    for (int i = 0; i < LEN; i++) begin
      longint qv;
      qv = (e[i] << 16) / s;
      if (qv > 65535) qv = 65535;
      exp_q.push_back(int'(qv));
    end
  endtask

  task automatic load_consts();
    for (int n = 0; n < 16; n++) begin
      @(negedge clk);
      cw_en = 1'b1; cw_addr = 4'(n); cw_data = 16'(cst[n]);
    end
    @(negedge clk);
    cw_en = 1'b0;
  endtask

  task automatic default_consts();
    for (int n = 0; n < 16; n++)
      cst[n] = $rtoi($exp(-(2.0 ** (8 - n))) * 16384.0 + 0.5);
  endtask

  task automatic run_case(input string req, input bit disturb);
    int cnt;
    cur_req = req;
    for (int i = 0; i < LEN; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_idx = 3'(i); ld_data = 16'(vec[i]);
    end
    @(negedge clk);
    ld_en = 1'b0;
    push_expected();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2", busy, 1);
    cnt = 0;
    while (cnt < 2000) begin
      @(negedge clk);
      cnt++;
      if (disturb && cnt >= 20 && cnt < 24) begin
        ld_en = 1'b1; ld_idx = 3'(cnt); ld_data = 16'h7fff;
        cw_en = 1'b1; cw_addr = 4'(cnt - 12); cw_data = 16'h0000;
        start = 1'b1;
      end else begin
        ld_en = 1'b0; cw_en = 1'b0; start = 1'b0;
      end
      if (out_valid) break;
      check(busy == 1'b1, "R2", busy, 1);
    end
    check(cnt == 34 * LEN, "R7", cnt, 34 * LEN);
    repeat (LEN) @(negedge clk);
    check(done == 1'b1, "R8", done, 1);
    check(busy == 1'b0 && out_valid == 1'b0, "R8", {busy, out_valid}, 0);
    check(exp_q.size() == 0, "R7", exp_q.size(), 0);
    exp_q.delete();
    @(negedge clk);
    check(done == 1'b0, "R8", done, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, "watchdog", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && out_valid == 0 && out_data == 0, "R1",
          {busy, done, out_valid, out_data}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && done == 0 && out_valid == 0, "R1", {busy, done, out_valid}, 0);

    default_consts();
    load_consts();

    vec = '{128, 0, -128, 256, 64, -64, 192, 32};
    run_case("R3 R4 R6", 1'b0);

    vec = '{1128, 1000, 872, 1256, 1064, 936, 1192, 1032};
    run_case("R5", 1'b0);

    vec = '{-30000, -30000, -30000, -30000, -30000, -30000, -30000, -30000};
    run_case("R5", 1'b0);

    vec = '{-32768, -32768, 32767, -32768, -32768, -32768, -32768, -32768};
    run_case("R6", 1'b0);

    vec = '{-5, 7, 100, -300, 99, 3, 0, -1};
    run_case("R9", 1'b1);
    run_case("R9", 1'b0);

    for (int n = 0; n < 16; n++) cst[n] = 16384;
    load_consts();
    vec = '{500, -20000, 3, 17, -1, 0, 32000, 77};
    run_case("R10", 1'b0);

    for (int n = 0; n < 16; n++) cst[n] = 32768;
    load_consts();
    vec = '{0, -15, -1, -3, -7, -2, -4, -8};
    run_case("R4", 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule